// File: doc/BRIEF.md
# RFID Tag Frame Parser

This block takes a stream of already recovered bits, each marked by a one-cycle valid strobe, and turns it into 40-bit tag identifiers. While idle it hunts for the frame start, which is a run of nine ones. After the start run it reads ten rows. Each row is a four-bit nibble, sent most significant bit first, followed by an even-parity bit for that row. A five-bit trailer closes the frame: four column-parity bits, then a stop bit.

When the frame is clean, the block presents the 40 collected bits on its tag output together with a one-cycle valid strobe. The first two nibbles form the upper byte of the tag, which is the version/customer field. At the end of every frame, clean or not, the block pulses a done strobe and updates three error flags: row parity, column parity and stop bit. It then resumes hunting for the next start run.

Top module: `tag_frame_parser`

## Requirements
- R1: After a synchronous active-low reset, tag_out is zero, and tag_valid, frame_done, row_err, col_err and stop_err are all low.
- R2: Framing starts only on the ninth consecutive accepted 1 bit while hunting. An accepted 0 restarts the count, so eight ones followed by a zero never start a frame.
- R3: After the start run, the block takes 10 rows of 5 bits. Each row is 4 data bits, first-received bit being the nibble MSB, then a parity bit that must equal the XOR of those 4 data bits.
- R4: If any row parity bit mismatches, row_err is high at frame end and tag_valid stays low.
- R5: The 4 trailer parity bits arrive in column order. Column 0 is the first-received (MSB) bit of each nibble. Each column bit must equal the XOR of that column over all 10 rows. Any mismatch sets col_err at frame end and blocks tag_valid.
- R6: The fifth trailer bit is the stop bit and must be 0. A 1 sets stop_err and blocks tag_valid.
- R7: tag_out holds the 10 nibbles in arrival order. The first nibble is in bits [39:36] and the second in [35:32], so the version/customer byte is [39:32].
- R8: tag_valid is high for exactly one cycle, on the cycle after the stop bit is accepted. tag_out changes only with tag_valid and keeps its value through rejected frames.
- R9: frame_done pulses for one cycle on the cycle after every stop bit is accepted. row_err, col_err and stop_err update on that same cycle and hold until the next frame end.
- R10: Cycles with bit_valid low are ignored, whatever bit_in does. After the stop bit, the block hunts for a new start run.
- R11: The column accumulators, the row-error state and the tag assembly are cleared at every frame end, so a clean frame that follows a corrupted one is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | bit_in carries a recovered bit this cycle |
| bit_in | input | 1 | Recovered data bit |
| tag_out | output | 40 | Last accepted tag; version/customer byte in [39:32] |
| tag_valid | output | 1 | One-cycle strobe for a newly accepted tag |
| frame_done | output | 1 | One-cycle strobe at the end of every frame |
| row_err | output | 1 | Last frame had a row parity mismatch |
| col_err | output | 1 | Last frame had a column parity mismatch |
| stop_err | output | 1 | Last frame had a stop bit of 1 |

## Verification
The bench builds the parser with its default parameters: a nine-one start run, ten rows and four columns, which gives a 64-bit frame and a 40-bit tag. With these values the bench can reach the exact field positions and check the byte split between the version/customer field and the data. It also covers a start run broken one bit short of complete, and corruption of a single row bit, a single column bit or the stop bit. Further cases are a clean frame sent straight after bad ones, and frames spread out by idle cycles during which bit_in toggles.

// File: rtl/tfp_pkg.sv
// Package: shared types for the tag frame parser.
// Assumes: nothing beyond IEEE 1800-2017.
package tfp_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_PAYLOAD = 2'd1,
        ST_TRAILER = 2'd2
    } tfp_state_e;
endpackage

// File: rtl/tfp_header_det.sv
// Module: counts consecutive accepted ones while enabled and flags the
// bit that completes the start run.
// Assumes: HDR_ONES >= 2; enable is low outside the hunting state.
module tfp_header_det #(
    parameter int HDR_ONES = 9,
    localparam int CW = $clog2(HDR_ONES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic bit_valid,
    input  logic bit_in,
    output logic found
);
    logic [CW-1:0] ones_q;

    assign found = enable && bit_valid && bit_in && (ones_q == CW'(HDR_ONES - 1));

    // Purpose: track the length of the current run of ones.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            ones_q <= '0;
        end else if (bit_valid) begin
            if (!bit_in || found) ones_q <= '0;
            else                  ones_q <= ones_q + 1'b1;
        end
    end

    p_run_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q <= CW'(HDR_ONES - 1));
    p_found_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        found |=> (ones_q == '0));
endmodule

// File: rtl/tfp_parity_acc.sv
// Module: keeps the running column XORs, the current row XOR and sticky
// row and column error flags for one frame.
// Assumes: the strobes are mutually exclusive; idx < COLS when a strobe is high.
module tfp_parity_acc #(
    parameter int COLS = 4,
    localparam int IW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          data_we,
    input  logic          rpar_we,
    input  logic          cpar_we,
    input  logic [IW-1:0] idx,
    input  logic          bit_in,
    output logic          row_err,
    output logic          col_err
);
    logic [COLS-1:0] col_acc_q;
    logic            row_x_q;

    // Purpose: one XOR accumulator per data column.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                    col_acc_q[c] <= 1'b0;
            else if (data_we && idx == IW'(c))    col_acc_q[c] <= col_acc_q[c] ^ bit_in;
        end
    end

    // Purpose: XOR of the data bits of the row being received.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || rpar_we) row_x_q <= 1'b0;
        else if (data_we)             row_x_q <= row_x_q ^ bit_in;
    end

    // Purpose: sticky row parity mismatch for this frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                    row_err <= 1'b0;
        else if (rpar_we && bit_in != row_x_q) row_err <= 1'b1;
    end

    // Purpose: sticky column parity mismatch for this frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                               col_err <= 1'b0;
        else if (cpar_we && bit_in != col_acc_q[idx])    col_err <= 1'b1;
    end

    p_clr_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (col_acc_q == '0 && !row_err && !col_err && !row_x_q));
    p_row_err_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_err) |-> $past(rpar_we));
    p_col_err_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_err) |-> $past(cpar_we));
endmodule

// File: rtl/tfp_tag_shift.sv
// Module: assembles the tag by shifting in data bits in arrival order.
// Assumes: shift_en is high only for data bits, never together with clr.
module tfp_tag_shift #(
    parameter int TAG_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [TAG_W-1:0] tag
);
    // Purpose: shift register for the tag under assembly.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  tag <= '0;
        else if (shift_en)  tag <= {tag[TAG_W-2:0], bit_in};
    end

    p_clr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (tag == '0));
endmodule

// File: rtl/tag_frame_parser.sv
// Module: top of the tag frame parser. Hunts for the start run, walks the
// row/column frame with a small sequencer and publishes clean tags.
// Assumes: bits arrive already recovered, one per bit_valid strobe.
module tag_frame_parser
    import tfp_pkg::*;
#(
    parameter int HDR_ONES = 9,
    parameter int ROWS     = 10,
    parameter int COLS     = 4,
    localparam int TAG_W   = ROWS * COLS,
    localparam int GW      = $clog2(COLS + 1),
    localparam int RW      = $clog2(ROWS),
    localparam int IW      = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [TAG_W-1:0] tag_out,
    output logic             tag_valid,
    output logic             frame_done,
    output logic             row_err,
    output logic             col_err,
    output logic             stop_err
);
    tfp_state_e       state_q;
    logic [GW-1:0]    pos_q;
    logic [RW-1:0]    row_q;
    logic             hdr_found;
    logic             grp_last;
    logic             data_we, rpar_we, cpar_we, stop_we;
    logic             acc_row_err, acc_col_err;
    logic [TAG_W-1:0] tag_asm;

    assign grp_last = (pos_q == GW'(COLS));
    assign data_we  = bit_valid && state_q == ST_PAYLOAD && !grp_last;
    assign rpar_we  = bit_valid && state_q == ST_PAYLOAD &&  grp_last;
    assign cpar_we  = bit_valid && state_q == ST_TRAILER && !grp_last;
    assign stop_we  = bit_valid && state_q == ST_TRAILER &&  grp_last;

    tfp_header_det #(.HDR_ONES(HDR_ONES)) u_hdr (
        .clk(clk), .rst_n(rst_n), .enable(state_q == ST_HUNT),
        .bit_valid(bit_valid), .bit_in(bit_in), .found(hdr_found));

    tfp_parity_acc #(.COLS(COLS)) u_par (
        .clk(clk), .rst_n(rst_n), .clr(stop_we),
        .data_we(data_we), .rpar_we(rpar_we), .cpar_we(cpar_we),
        .idx(pos_q[IW-1:0]), .bit_in(bit_in),
        .row_err(acc_row_err), .col_err(acc_col_err));

    tfp_tag_shift #(.TAG_W(TAG_W)) u_tag (
        .clk(clk), .rst_n(rst_n), .clr(stop_we), .shift_en(data_we),
        .bit_in(bit_in), .tag(tag_asm));

    // Purpose: frame sequencer (state, position in group, row number).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            row_q   <= '0;
        end else begin
            case (state_q)
                ST_HUNT: begin
                    if (hdr_found) begin
                        state_q <= ST_PAYLOAD;
                        pos_q   <= '0;
                        row_q   <= '0;
                    end
                end
                ST_PAYLOAD: begin
                    if (bit_valid) begin
                        if (grp_last) begin
                            pos_q <= '0;
                            if (row_q == RW'(ROWS - 1)) begin
                                state_q <= ST_TRAILER;
                                row_q   <= '0;
                            end else begin
                                row_q <= row_q + 1'b1;
                            end
                        end else begin
                            pos_q <= pos_q + 1'b1;
                        end
                    end
                end
                ST_TRAILER: begin
                    if (bit_valid) begin
                        if (grp_last) begin
                            state_q <= ST_HUNT;
                            pos_q   <= '0;
                        end else begin
                            pos_q <= pos_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    // Purpose: publish frame verdict and, when clean, the tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_out    <= '0;
            tag_valid  <= 1'b0;
            frame_done <= 1'b0;
            row_err    <= 1'b0;
            col_err    <= 1'b0;
            stop_err   <= 1'b0;
        end else begin
            tag_valid  <= 1'b0;
            frame_done <= stop_we;
            if (stop_we) begin
                row_err  <= acc_row_err;
                col_err  <= acc_col_err;
                stop_err <= bit_in;
                if (!acc_row_err && !acc_col_err && !bit_in) begin
                    tag_valid <= 1'b1;
                    tag_out   <= tag_asm;
                end
            end
        end
    end

    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |=> !tag_valid);
    p_tag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_valid |-> $stable(tag_out));
    p_valid_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> (!row_err && !col_err && !stop_err));
    p_valid_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> frame_done);
    p_done_hunting_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (state_q == ST_HUNT));
endmodule

// File: tb/tag_frame_parser_bench.sv
module tag_frame_parser_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HDR  = 9;
    localparam int ROWS = 10;
    localparam int COLS = 4;
    localparam int TW   = ROWS * COLS;
    localparam int FLEN = HDR + ROWS * (COLS + 1) + COLS + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_valid = 1'b0;
    logic          bit_in = 1'b0;
    logic [TW-1:0] tag_out;
    logic          tag_valid, frame_done, row_err, col_err, stop_err;

    int n_chk  = 0;
    int n_fail = 0;
    int n_done = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tag_frame_parser #(.HDR_ONES(HDR), .ROWS(ROWS), .COLS(COLS)) u_tag_frame_parser (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .tag_out(tag_out), .tag_valid(tag_valid), .frame_done(frame_done),
        .row_err(row_err), .col_err(col_err), .stop_err(stop_err));

    always @(posedge clk) if (rst_n && frame_done) n_done <= n_done + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Builds a frame; bad_row/bad_col = -1 for none.
    function automatic logic [FLEN-1:0] make_frame(input logic [TW-1:0] tag,
            input int bad_row, input int bad_col, input logic stop);
        logic [FLEN-1:0] f = '0;
        logic [COLS-1:0] cp = '0;
        int p = FLEN - 1;
        for (int h = 0; h < HDR; h++) begin f[p] = 1'b1; p--; end
        for (int r = 0; r < ROWS; r++) begin
            logic [3:0] nb = 4'(tag >> (TW - 4 * (r + 1)));
            for (int c = 0; c < COLS; c++) begin
                f[p] = nb[3 - c]; cp[c] = cp[c] ^ nb[3 - c]; p--;
            end
            f[p] = (^nb) ^ (r == bad_row); p--;
        end
        for (int c = 0; c < COLS; c++) begin f[p] = cp[c] ^ (c == bad_col); p--; end
        f[p] = stop;
        return f;
    endfunction

    task automatic send_bit(input logic b, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk); bit_valid = 1'b0; bit_in = ~bit_in;
        end
        @(negedge clk); bit_valid = 1'b1; bit_in = b;
        @(negedge clk); bit_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [FLEN-1:0] f, input int gap);
        for (int i = FLEN - 1; i >= 0; i--) send_bit(f[i], gap);
    endtask

    task automatic expect_verdict(input string req, input logic v, input logic re,
            input logic ce, input logic se, input logic [TW-1:0] tg);
        chk({req, " frame_done"}, 64'(frame_done), 64'd1);
        chk({req, " tag_valid"},  64'(tag_valid), 64'(v));
        chk({req, " row_err"},    64'(row_err), 64'(re));
        chk({req, " col_err"},    64'(col_err), 64'(ce));
        chk({req, " stop_err"},   64'(stop_err), 64'(se));
        chk({req, " tag_out"},    64'(tag_out), 64'(tg));
        @(negedge clk);
        chk({req, " R8 tag_valid single cycle"}, 64'(tag_valid), 64'd0);
        chk({req, " R9 frame_done single cycle"}, 64'(frame_done), 64'd0);
        chk({req, " R9 flags held"}, 64'({row_err, col_err, stop_err}), 64'({re, ce, se}));
    endtask

    task automatic t_reset();
        chk("R1 tag_out", 64'(tag_out), 64'd0);
        chk("R1 strobes", 64'({tag_valid, frame_done}), 64'd0);
        chk("R1 flags", 64'({row_err, col_err, stop_err}), 64'd0);
    endtask

    task automatic t_good();
        send_frame(make_frame(40'h1A2B3C4D5E, -1, -1, 1'b0), 0);
        expect_verdict("R3 R7 good", 1'b1, 1'b0, 1'b0, 1'b0, 40'h1A2B3C4D5E);
        chk("R7 version/customer byte", 64'(tag_out[39:32]), 64'h1A);
    endtask

    task automatic t_header_break();
        logic [FLEN-1:0] f = make_frame('0, -1, -1, 1'b0);
        int d0 = n_done;
        for (int i = 0; i < HDR - 1; i++) send_bit(1'b1, 0);
        send_bit(1'b0, 0);
        for (int i = FLEN - HDR - 1; i >= 0; i--) send_bit(f[i], 0);
        repeat (3) @(negedge clk);
        chk("R2 eight ones then zero start nothing", 64'(n_done - d0), 64'd0);
        for (int i = 0; i < HDR - 1; i++) send_bit(1'b1, 0);
        send_bit(1'b0, 0);
        send_frame(make_frame(40'hF0E1D2C3B4, -1, -1, 1'b0), 0);
        expect_verdict("R2 count restarts after zero", 1'b1, 1'b0, 1'b0, 1'b0, 40'hF0E1D2C3B4);
    endtask

    task automatic t_row_err();
        send_frame(make_frame(40'h0123456789, 4, -1, 1'b0), 0);
        expect_verdict("R4 row parity", 1'b0, 1'b1, 1'b0, 1'b0, 40'hF0E1D2C3B4);
    endtask

    task automatic t_col_err();
        send_frame(make_frame(40'h0123456789, -1, 0, 1'b0), 0);
        expect_verdict("R5 column 0 parity", 1'b0, 1'b0, 1'b1, 1'b0, 40'hF0E1D2C3B4);
        send_frame(make_frame(40'h0123456789, -1, 3, 1'b0), 0);
        expect_verdict("R5 column 3 parity", 1'b0, 1'b0, 1'b1, 1'b0, 40'hF0E1D2C3B4);
    endtask

    task automatic t_stop_err();
        send_frame(make_frame(40'h0123456789, -1, -1, 1'b1), 0);
        expect_verdict("R6 stop bit", 1'b0, 1'b0, 1'b0, 1'b1, 40'hF0E1D2C3B4);
    endtask

    task automatic t_recover();
        send_frame(make_frame(40'h8899AABBCC, -1, -1, 1'b0), 0);
        expect_verdict("R11 clean after bad", 1'b1, 1'b0, 1'b0, 1'b0, 40'h8899AABBCC);
    endtask

    task automatic t_gaps();
        send_frame(make_frame(40'h5A5AC3C3E7, -1, -1, 1'b0), 3);
        expect_verdict("R10 idle cycles ignored", 1'b1, 1'b0, 1'b0, 1'b0, 40'h5A5AC3C3E7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_good();
        t_header_break();
        t_row_err();
        t_col_err();
        t_stop_err();
        t_recover();
        t_gaps();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule